// File: doc/BRIEF.md
# Speculative Load Violation Detector

Under a sequentially consistent memory model, loads may read their data before they become the oldest instruction in the machine. This block records where each such load read from and watches for anything that could have made that value stale before the load retires. Each time a load executes early, the core presents its tag and address. The block keeps the cache-block part of that address in a circular table, stored in program order. When the oldest load retires, the core signals a commit. Each cycle a snoop port carries either a remote write or invalidation, or a local eviction. If any of these touches a tracked block, the block reports a violation, and the core uses it to roll back.

The detector is deliberately conservative. It matches on block addresses, so a write to an unrelated word of the same block counts as a hit. Evictions are treated exactly like remote writes. A load that arrives while the table is full is reported as a violation instead of being dropped silently. The violation output is a one-cycle pulse that carries the tag of the oldest affected load. That entry and every younger entry leave the table, because the rollback will reissue them. The core can also discard entries: a squash discards from a given tag onward, and a flush empties the whole table.

Top module: `spec_load_guard`

## Requirements
- R1: After reset the table is empty and `viol_valid` is 0. A snoop to any address then raises no violation.
- R2: A snoop (`sn_valid`) whose block matches a tracked, uncommitted load raises `viol_valid` for exactly one cycle, in the cycle after the snoop, with `viol_tag` equal to that load's tag. The matched entry leaves the table.
- R3: Address bits [OFFSET_W-1:0] are ignored when matching: a snoop to another word of the same block hits, and a snoop to a different block does not.
- R4: `cm_valid` frees the oldest entry. A later snoop to that load's block raises no violation, and younger entries stay tracked.
- R5: When several entries match one snoop, `viol_tag` is the tag of the oldest matching entry. That entry and all younger entries are discarded, and older entries stay tracked.
- R6: A load presented while all DEPTH entries are occupied and no commit occurs raises a violation, one cycle later, carrying that load's own tag. The load is not recorded.
- R7: A load that arrives in the same cycle as a commit on a full table is accepted and raises no violation.
- R8: `sq_valid` with `sq_tag` discards the entry holding that tag and all younger entries, raises no violation, and leaves older entries tracked.
- R9: `flush` empties the table and suppresses any violation in that cycle, whatever the other inputs do.
- R10: A snoop in the same cycle as a commit is not matched against the load that is committing.
- R11: A load presented in the same cycle as a snoop hit or a squash hit is not recorded.
- R12: Loads that arrive while the table has room, with no snoop, never raise a violation, whatever their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load has executed speculatively |
| ld_tag | input | TAG_W | Tag of that load |
| ld_addr | input | ADDR_W | Byte address that load read |
| cm_valid | input | 1 | Oldest tracked load retires |
| sq_valid | input | 1 | Discard from a tag onward |
| sq_tag | input | TAG_W | Oldest tag to discard |
| flush | input | 1 | Discard every entry |
| sn_valid | input | 1 | Remote write/invalidate or local eviction |
| sn_addr | input | ADDR_W | Byte address of the snoop |
| viol_valid | output | 1 | Violation pulse |
| viol_tag | output | TAG_W | Tag of the oldest affected load |

## Verification
Entries are never read out directly, so a corrupted head, count or stored block only becomes visible when a later snoop or load produces, or fails to produce, a pulse. The directed scenarios therefore follow each table change with snoops to the blocks that should have been freed and the blocks that should remain. A wrong pointer shows up in the cycle after the next snoop to an affected block: a missing pulse, an extra pulse, or a wrong `viol_tag`. Overflow and commit-on-full tests fill the table to its boundary, so any error in the count shows up within one load of that boundary.

// File: rtl/slg_pkg.sv
package slg_pkg;
   typedef enum logic [1:0] {
      VS_NONE  = 2'd0,
      VS_SNOOP = 2'd1,
      VS_FULL  = 2'd2
   } vsrc_e;
endpackage

// File: rtl/slg_first_hit.sv
module slg_first_hit #(
   parameter int N  = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/slg_entry_store.sv
module slg_entry_store #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 6,
   parameter int BLK_W = 26,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [PTR_W-1:0]             wr_ptr,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic [BLK_W-1:0]             wr_blk,
   output logic [DEPTH-1:0][TAG_W-1:0]  tags,
   output logic [DEPTH-1:0][BLK_W-1:0]  blks
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tags[e] <= '0;
            blks[e] <= '0;
         end else if (wr_en && wr_ptr == PTR_W'(e)) begin
            tags[e] <= wr_tag;
            blks[e] <= wr_blk;
         end
      end
   end
endmodule

// File: rtl/slg_age_view.sv
module slg_age_view #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 6,
   parameter int BLK_W = 26,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [PTR_W-1:0]             head,
   input  logic [CNT_W-1:0]             count,
   input  logic                         skip_head,
   input  logic [DEPTH-1:0][TAG_W-1:0]  tags,
   input  logic [DEPTH-1:0][BLK_W-1:0]  blks,
   input  logic                         sq_valid,
   input  logic [TAG_W-1:0]             sq_tag,
   input  logic                         sn_valid,
   input  logic [BLK_W-1:0]             sn_blk,
   output logic [DEPTH-1:0]             sq_hit,
   output logic [DEPTH-1:0]             sn_hit
);
   for (genvar a = 0; a < DEPTH; a++) begin : g_age
      logic [PTR_W-1:0] phys;
      logic             elig;
      assign phys = head + PTR_W'(a);
      assign elig = (CNT_W'(a) < count) && !(skip_head && a == 0);
      assign sq_hit[a] = sq_valid && elig && (tags[phys] == sq_tag);
      assign sn_hit[a] = sn_valid && elig && (blks[phys] == sn_blk);
   end
endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard
   import slg_pkg::*;
#(
   parameter int TAG_W    = 6,
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 6,
   parameter int DEPTH    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              cm_valid,
   input  logic              sq_valid,
   input  logic [TAG_W-1:0]  sq_tag,
   input  logic              flush,
   input  logic              sn_valid,
   input  logic [ADDR_W-1:0] sn_addr,
   output logic              viol_valid,
   output logic [TAG_W-1:0]  viol_tag
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int BLK_W = ADDR_W - OFFSET_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (OFFSET_W < 1 || OFFSET_W >= ADDR_W) begin : g_bad_off
      $error("OFFSET_W must lie between 1 and ADDR_W-1");
   end

   logic [PTR_W-1:0] head_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DEPTH-1:0][TAG_W-1:0] tags;
   logic [DEPTH-1:0][BLK_W-1:0] blks;
   logic [BLK_W-1:0] ld_blk, sn_blk;
   logic unused_offsets;

   assign ld_blk = ld_addr[ADDR_W-1:OFFSET_W];
   assign sn_blk = sn_addr[ADDR_W-1:OFFSET_W];
   assign unused_offsets = ^{ld_addr[OFFSET_W-1:0], sn_addr[OFFSET_W-1:0]};

   logic cm_eff;
   assign cm_eff = cm_valid && (cnt_q != '0);

   logic [DEPTH-1:0] sq_hit, sn_hit_raw, sn_hit, below_sq;
   logic             sq_any, sn_any;
   logic [PTR_W-1:0] sq_idx, sn_idx;

   slg_age_view #(.DEPTH(DEPTH), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_view (
      .head(head_q), .count(cnt_q), .skip_head(cm_eff),
      .tags(tags), .blks(blks),
      .sq_valid(sq_valid), .sq_tag(sq_tag),
      .sn_valid(sn_valid), .sn_blk(sn_blk),
      .sq_hit(sq_hit), .sn_hit(sn_hit_raw)
   );

   slg_first_hit #(.N(DEPTH)) u_sq_pick (.req(sq_hit), .any(sq_any), .idx(sq_idx));

   for (genvar a = 0; a < DEPTH; a++) begin : g_mask
      assign below_sq[a] = !sq_any || (PTR_W'(a) < sq_idx);
   end
   assign sn_hit = sn_hit_raw & below_sq;

   slg_first_hit #(.N(DEPTH)) u_sn_pick (.req(sn_hit), .any(sn_any), .idx(sn_idx));

   logic [CNT_W-1:0] cut, cnt_nxt;
   logic [PTR_W-1:0] wr_ptr;
   logic             accept, full, wr_en;
   vsrc_e            vsrc;

   always_comb begin
      if (sn_any)      cut = CNT_W'(sn_idx);
      else if (sq_any) cut = CNT_W'(sq_idx);
      else             cut = cnt_q;
   end

   assign accept = ld_valid && !sn_any && !sq_any && !flush;
   assign full   = (cnt_q == CNT_W'(DEPTH)) && !cm_eff;
   assign wr_en  = accept && !full;
   assign wr_ptr = head_q + cnt_q[PTR_W-1:0];
   assign cnt_nxt = cut - CNT_W'(cm_eff) + CNT_W'(wr_en);

   always_comb begin
      if (flush)               vsrc = VS_NONE;
      else if (sn_any)         vsrc = VS_SNOOP;
      else if (accept && full) vsrc = VS_FULL;
      else                     vsrc = VS_NONE;
   end

   slg_entry_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
      .wr_tag(ld_tag), .wr_blk(ld_blk), .tags(tags), .blks(blks)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q     <= '0;
         cnt_q      <= '0;
         viol_valid <= 1'b0;
         viol_tag   <= '0;
      end else begin
         if (flush) begin
            head_q <= '0;
            cnt_q  <= '0;
         end else begin
            head_q <= head_q + PTR_W'(cm_eff);
            cnt_q  <= cnt_nxt;
         end
         viol_valid <= (vsrc != VS_NONE);
         case (vsrc)
            VS_SNOOP: viol_tag <= tags[head_q + sn_idx];
            VS_FULL:  viol_tag <= ld_tag;
            default:  viol_tag <= viol_tag;
         endcase
      end
   end

   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!viol_valid && cnt_q == '0));

   a_r12_room_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !sn_valid && !flush && cnt_q < CNT_W'(DEPTH)) |=> !viol_valid);

   a_r2_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> $past(sn_valid || ld_valid));

   a_r4_commit_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && cnt_q != '0 && !ld_valid && !flush) |=> cnt_q < $past(cnt_q));

   a_r8_squash_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && !ld_valid && !flush) |=> cnt_q <= $past(cnt_q));
endmodule

// File: tb/spec_load_guard_bench.sv
module spec_load_guard_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ld_valid, cm_valid, sq_valid, flush, sn_valid;
   logic [5:0]  ld_tag, sq_tag;
   logic [31:0] ld_addr, sn_addr;
   logic        viol_valid;
   logic [5:0]  viol_tag;
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   spec_load_guard u_spec_load_guard (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
      .cm_valid(cm_valid), .sq_valid(sq_valid), .sq_tag(sq_tag),
      .flush(flush), .sn_valid(sn_valid), .sn_addr(sn_addr),
      .viol_valid(viol_valid), .viol_tag(viol_tag)
   );

   function automatic logic [31:0] ba(input int b, input int off);
      return 32'h0001_0000 + 32'(b) * 64 + 32'(off);
   endfunction

   task automatic idle();
      ld_valid = 0; cm_valid = 0; sq_valid = 0; flush = 0; sn_valid = 0;
      ld_tag = 0; sq_tag = 0; ld_addr = 0; sn_addr = 0;
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic expect_v(input string req, input bit ev, input logic [5:0] et);
      total++;
      if (viol_valid !== ev || (ev && viol_tag !== et)) begin
         bad++;
         $display("FAIL %s: viol_valid=%0b tag=%0d expected valid=%0b tag=%0d",
                  req, viol_valid, viol_tag, ev, et);
      end
   endtask

   task automatic load(input logic [5:0] t, input logic [31:0] a);
      idle(); ld_valid = 1; ld_tag = t; ld_addr = a; tick(); idle();
   endtask

   task automatic snoop(input logic [31:0] a);
      idle(); sn_valid = 1; sn_addr = a; tick(); idle();
   endtask

   task automatic t_reset();
      expect_v("R1", 0, 0);
      snoop(ba(0, 0));
      expect_v("R1", 0, 0);
   endtask

   task automatic t_basic();
      load(1, ba(1, 0));
      snoop(ba(1, 8));
      expect_v("R2", 1, 1);
      snoop(ba(1, 0));
      expect_v("R2", 0, 0);
      load(2, ba(2, 4));
      snoop(ba(3, 4));
      expect_v("R3", 0, 0);
      snoop(ba(2, 60));
      expect_v("R3", 1, 2);
   endtask

   task automatic t_commit();
      load(3, ba(1, 0));
      load(4, ba(2, 0));
      idle(); cm_valid = 1; tick(); idle();
      snoop(ba(1, 0));
      expect_v("R4", 0, 0);
      snoop(ba(2, 0));
      expect_v("R4", 1, 4);
   endtask

   task automatic t_oldest();
      load(5, ba(1, 0)); load(6, ba(2, 0)); load(7, ba(1, 0)); load(8, ba(3, 0));
      snoop(ba(1, 0));
      expect_v("R5", 1, 5);
      snoop(ba(3, 0));
      expect_v("R5", 0, 0);
      snoop(ba(2, 0));
      expect_v("R5", 0, 0);
      load(9, ba(4, 0)); load(10, ba(5, 0)); load(11, ba(6, 0));
      snoop(ba(5, 0));
      expect_v("R5", 1, 10);
      snoop(ba(6, 0));
      expect_v("R5", 0, 0);
      snoop(ba(4, 0));
      expect_v("R5", 1, 9);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < 16; i++) begin
         load(6'(20 + i), ba(100 + i, 0));
         expect_v("R12", 0, 0);
      end
      load(40, ba(200, 0));
      expect_v("R6", 1, 40);
      snoop(ba(200, 0));
      expect_v("R6", 0, 0);
      idle(); cm_valid = 1; ld_valid = 1; ld_tag = 41; ld_addr = ba(200, 0); tick(); idle();
      expect_v("R7", 0, 0);
      snoop(ba(200, 0));
      expect_v("R7", 1, 41);
      snoop(ba(100, 0));
      expect_v("R4", 0, 0);
      idle(); flush = 1; tick(); idle();
      expect_v("R9", 0, 0);
      snoop(ba(101, 0));
      expect_v("R9", 0, 0);
   endtask

   task automatic t_squash();
      load(50, ba(1, 0)); load(51, ba(2, 0)); load(52, ba(3, 0));
      idle(); sq_valid = 1; sq_tag = 51; tick(); idle();
      expect_v("R8", 0, 0);
      snoop(ba(2, 0));
      expect_v("R8", 0, 0);
      snoop(ba(3, 0));
      expect_v("R8", 0, 0);
      snoop(ba(1, 0));
      expect_v("R8", 1, 50);
   endtask

   task automatic t_commit_snoop();
      load(60, ba(1, 0));
      idle(); cm_valid = 1; sn_valid = 1; sn_addr = ba(1, 0); tick(); idle();
      expect_v("R10", 0, 0);
      snoop(ba(1, 0));
      expect_v("R10", 0, 0);
   endtask

   task automatic t_same_cycle_drop();
      load(61, ba(1, 0));
      idle(); sn_valid = 1; sn_addr = ba(1, 0); ld_valid = 1; ld_tag = 62; ld_addr = ba(2, 0);
      tick(); idle();
      expect_v("R11", 1, 61);
      snoop(ba(2, 0));
      expect_v("R11", 0, 0);
      load(63, ba(1, 0));
      idle(); sq_valid = 1; sq_tag = 63; ld_valid = 1; ld_tag = 12; ld_addr = ba(2, 0);
      tick(); idle();
      expect_v("R11", 0, 0);
      snoop(ba(2, 0));
      expect_v("R11", 0, 0);
      snoop(ba(1, 0));
      expect_v("R8", 0, 0);
   endtask

   task automatic t_flush();
      load(13, ba(7, 0));
      idle(); flush = 1; sn_valid = 1; sn_addr = ba(7, 0); tick(); idle();
      expect_v("R9", 0, 0);
      snoop(ba(7, 0));
      expect_v("R9", 0, 0);
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_commit();
      t_oldest();
      t_overflow();
      t_squash();
      t_commit_snoop();
      t_same_cycle_drop();
      t_flush();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule